// File: doc/BRIEF.md
# Self-Timed Program Sequencer with Ready/Busy Status

This block sits behind the serial command decoder of a small nonvolatile word store. It keeps the lock that guards every change to the stored words. It holds the one modifying command that was last decoded while the part stays selected. When chip select is released, it runs a timed program cycle that needs no serial clock. At the end of that cycle it issues one update on the array write port.

While a cycle runs or has just completed, the host can select the part again and poll the serial output. A low level there means the cycle is still in progress and a high level means it is done. Once the part is ready, the host can take the output off the line by clocking in a single 1.

Every timing value is counted on the free-running internal clock. The program-cycle length is a parameter, so a testbench can shorten it.

Top module: `prog_sequencer`

## Requirements
- R1: After reset the lock is closed, `busy` is 0, `arr_we` is 0 and `do_oe` is 0 even with `cs` high.
- R2: While the lock is closed, a `cmd_write`, `cmd_clear`, `cmd_clear_all` or `cmd_fill_all` strobe followed by a falling `cs` produces no busy period and no `arr_we` pulse.
- R3: A `cmd_unlock` strobe opens the lock. The lock stays open across any number of cycles until a `cmd_lock` strobe closes it again.
- R4: The program cycle starts on the first clock that samples `cs` low after it was high, with a modifying command pending. `busy` then stays high for exactly `PROG_CYCLES` clocks, whatever `sk` does.
- R5: Each cycle gives exactly one `arr_we` pulse, in the first clock after `busy` falls. Its fields are set by the command. Write: `arr_all`=0, `arr_addr`=address, `arr_wdata`=data. The old word needs no clear first. Clear: `arr_all`=0, address, all ones. Clear-all: `arr_all`=1, all ones. Fill-all: `arr_all`=1, data.
- R6: Every command strobe that arrives while `busy` is high has no effect. This covers a lock strobe, which therefore leaves the lock open, and a write strobe, which neither replaces the running command nor starts another cycle.
- R7: Once a cycle has started, `do_oe` equals `cs`. With `do_oe` high, `do_val` is 0 while busy and 1 when ready.
- R8: A rising `sk` with `di`=1 while `cs` is high and the part is ready clears `do_oe` from the next clock on. The same stimulus while busy leaves `do_oe` high.
- R9: A falling `cs` with no modifying command pending starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running internal timebase |
| rst_n | input | 1 | Power-on reset, active low |
| cs | input | 1 | Chip select, synchronous to `clk` |
| sk | input | 1 | Serial clock level, sampled on `clk` |
| di | input | 1 | Serial data input level |
| cmd_write | input | 1 | Decoded strobe: store data at one address |
| cmd_clear | input | 1 | Decoded strobe: set one word to all ones |
| cmd_clear_all | input | 1 | Decoded strobe: set every word to all ones |
| cmd_fill_all | input | 1 | Decoded strobe: store data at every address |
| cmd_unlock | input | 1 | Decoded strobe: open the modify lock |
| cmd_lock | input | 1 | Decoded strobe: close the modify lock |
| cmd_addr | input | AW | Address decoded with the strobe |
| cmd_data | input | DW | Data decoded with the strobe |
| arr_we | output | 1 | One-clock array write pulse |
| arr_all | output | 1 | Write applies to every address |
| arr_addr | output | AW | Target address |
| arr_wdata | output | DW | Word to store |
| busy | output | 1 | Program cycle in progress |
| do_val | output | 1 | Status level for the serial output |
| do_oe | output | 1 | Serial output driven with status |

## Verification
Some internal faults show up at the ports within a clock or two. A lock stuck open makes a busy period appear after a rejected command. A wrong start condition moves the rising edge of `busy` away from the clock after `cs` falls. A miscounted timer shows as a busy period that is not exactly `PROG_CYCLES` clocks long. A lost or overwritten pending command gives a wrong address, data or broadcast flag on the single write pulse. A faulty status flag shows on `do_oe` in the cycle after `cs` changes or after a cancelling `sk` edge. Strobes sent during the busy period are followed by a further cycle, which exposes any state those strobes corrupted.

// File: rtl/prog_sequencer.sv
module prog_sequencer #(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 250000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          sk,
  input  logic          di,
  input  logic          cmd_write,
  input  logic          cmd_clear,
  input  logic          cmd_clear_all,
  input  logic          cmd_fill_all,
  input  logic          cmd_unlock,
  input  logic          cmd_lock,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  output logic          arr_we,
  output logic          arr_all,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata,
  output logic          busy,
  output logic          do_val,
  output logic          do_oe
);

  localparam int CW = $clog2(PROG_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_BUSY} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          cs_q, sk_q, unlocked, show_sts, we_q;
  logic          p_all;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;

  wire run      = (st == S_BUSY);
  wire cs_fall  = cs_q & ~cs;
  wire sk_rise  = sk & ~sk_q;
  wire mod_cmd  = cmd_write | cmd_clear | cmd_clear_all | cmd_fill_all;
  wire any_cmd  = mod_cmd | cmd_unlock | cmd_lock;
  wire take     = ~run & mod_cmd & unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      cs_q     <= 1'b0;
      sk_q     <= 1'b0;
      unlocked <= 1'b0;
      show_sts <= 1'b0;
      we_q     <= 1'b0;
      p_all    <= 1'b0;
      p_addr   <= '0;
      p_data   <= '0;
    end else begin
      cs_q <= cs;
      sk_q <= sk;
      we_q <= 1'b0;

      if (!run && any_cmd)    show_sts <= 1'b0;
      if (!run && cmd_unlock) unlocked <= 1'b1;
      if (!run && cmd_lock)   unlocked <= 1'b0;
      if (show_sts && cs && sk_rise && di && !run) show_sts <= 1'b0;

      case (st)
        S_BUSY: begin
          if (cnt == '0) begin
            st   <= S_IDLE;
            we_q <= 1'b1;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: begin
          if (cs_fall) begin
            if (st == S_ARMED) begin
              st       <= S_BUSY;
              cnt      <= CW'(PROG_CYCLES - 1);
              show_sts <= 1'b1;
            end else begin
              st <= S_IDLE;
            end
          end else if (take) begin
            st     <= S_ARMED;
            p_all  <= cmd_clear_all | cmd_fill_all;
            p_addr <= cmd_addr;
            p_data <= (cmd_clear | cmd_clear_all) ? {DW{1'b1}} : cmd_data;
          end
        end
      endcase
    end
  end

  assign arr_we    = we_q;
  assign arr_all   = p_all;
  assign arr_addr  = p_addr;
  assign arr_wdata = p_data;
  assign busy      = run;
  assign do_oe     = cs & show_sts;
  assign do_val    = ~run;

  p_we_needs_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> unlocked);

  p_busy_starts_on_cs_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(cs));

  p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> !arr_we);

  p_we_follows_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> ($past(busy) && !busy));

  p_lock_frozen_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(unlocked));

  p_fields_frozen_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(arr_addr) && $stable(arr_wdata) && $stable(arr_all)));

  p_status_needs_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    do_oe |-> cs);

  p_status_busy_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_oe && busy) |-> !do_val);

  p_no_cancel_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(do_oe) && $past(busy) && busy && cs) |-> do_oe);

endmodule

// File: tb/prog_sequencer_test.sv
module prog_sequencer_test;

  localparam int AW  = 3;
  localparam int DW  = 8;
  localparam int CYC = 6;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b1, sk = 1'b0, di = 1'b0;
  logic cmd_write = 0, cmd_clear = 0, cmd_clear_all = 0, cmd_fill_all = 0;
  logic cmd_unlock = 0, cmd_lock = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic arr_we, arr_all, busy, do_val, do_oe;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;

  int n_chk = 0, n_fail = 0;

  prog_sequencer #(.AW(AW), .DW(DW), .PROG_CYCLES(CYC)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .cmd_write(cmd_write), .cmd_clear(cmd_clear), .cmd_clear_all(cmd_clear_all),
    .cmd_fill_all(cmd_fill_all), .cmd_unlock(cmd_unlock), .cmd_lock(cmd_lock),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .arr_we(arr_we), .arr_all(arr_all), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .busy(busy), .do_val(do_val), .do_oe(do_oe)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cmd(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cmd_write     = (op == 0);
    cmd_clear     = (op == 1);
    cmd_clear_all = (op == 2);
    cmd_fill_all  = (op == 3);
    cmd_unlock    = (op == 4);
    cmd_lock      = (op == 5);
    cmd_addr = a;
    cmd_data = d;
  endtask

  task automatic pulse(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    set_cmd(op, a, d);
    @(negedge clk);
    set_cmd(-1, '0, '0);
  endtask

  task automatic watch(input bit run, input bit ea, input logic [AW-1:0] aa,
                       input logic [DW-1:0] ed, input string req);
    int bc = 0, wc = 0, wk = 0;
    logic [AW+DW:0] got = '0;
    @(negedge clk) cs = 1'b0;
    for (int k = 1; k <= CYC + 3; k++) begin
      @(negedge clk);
      if (busy) bc++;
      if (arr_we) begin
        wc++;
        wk = k;
        got = {arr_all, arr_addr, arr_wdata};
      end
    end
    if (run) begin
      chk(bc == CYC, {req, " busy length"}, bc, CYC);
      chk(wc == 1, {req, " write pulses"}, wc, 1);
      chk(wk == CYC + 1, {req, " write timing"}, wk, CYC + 1);
      chk(got == {ea, aa, ed}, {req, " write fields"}, int'(got), int'({ea, aa, ed}));
    end else begin
      chk(bc == 0, {req, " no busy"}, bc, 0);
      chk(wc == 0, {req, " no write"}, wc, 0);
    end
    @(negedge clk) cs = 1'b1;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(arr_we == 0, "R1 arr_we", arr_we, 0);
    chk(do_oe == 0, "R1 do_oe", do_oe, 0);

    // R2 locked: every modifying command is rejected
    for (int op = 0; op < 4; op++) begin
      pulse(op, 3'd2, 8'h3C);
      watch(1'b0, 1'b0, '0, '0, "R2 locked");
    end

    // R3 unlock, then R4/R5 sweep of write over every address
    pulse(4, '0, '0);
    for (int a = 0; a < (1 << AW); a++) begin
      logic [DW-1:0] d = DW'((a * 37 + 5) ^ 8'hA0);
      pulse(0, AW'(a), d);
      watch(1'b1, 1'b0, AW'(a), d, "R5 write R3 R4");
    end

    // R5 clear one word, fill all, clear all
    pulse(1, 3'd3, 8'h12);
    watch(1'b1, 1'b0, 3'd3, 8'hFF, "R5 clear");
    pulse(3, 3'd6, 8'h5A);
    watch(1'b1, 1'b1, 3'd6, 8'h5A, "R5 fill all");
    pulse(2, 3'd1, 8'h00);
    watch(1'b1, 1'b1, 3'd1, 8'hFF, "R5 clear all");

    // R7 status hidden while deselected
    @(negedge clk) cs = 1'b0;
    @(negedge clk);
    chk(do_oe == 0, "R7 deselected do_oe", do_oe, 0);
    @(negedge clk) cs = 1'b1;
    @(negedge clk);
    chk(do_oe == 1 && do_val == 1, "R7 ready status", {do_oe, do_val}, 3);

    // R6/R7/R8 activity during a busy period
    begin
      int wc = 0;
      logic [AW+DW:0] got = '0;
      pulse(0, 3'd1, 8'h11);
      @(negedge clk) cs = 1'b0;
      for (int k = 1; k <= CYC + 2; k++) begin
        @(negedge clk);
        if (arr_we) begin
          wc++;
          got = {arr_all, arr_addr, arr_wdata};
        end
        if (k == 1) cs = 1'b1;
        if (k == 2) begin
          chk(do_oe == 1 && do_val == 0, "R7 busy status", {do_oe, do_val}, 2);
          set_cmd(5, '0, '0);
        end
        if (k == 3) set_cmd(0, 3'd5, 8'h77);
        if (k == 4) begin
          set_cmd(-1, '0, '0);
          sk = 1'b1;
          di = 1'b1;
        end
        if (k == 5) begin
          chk(do_oe == 1, "R8 no cancel while busy", do_oe, 1);
          sk = 1'b0;
          di = 1'b0;
        end
      end
      chk(wc == 1 && got == {1'b0, 3'd1, 8'h11}, "R6 running command kept",
          int'(got), int'({1'b0, 3'd1, 8'h11}));
      chk(do_oe == 1 && do_val == 1, "R7 ready after cycle", {do_oe, do_val}, 3);
      @(negedge clk) begin sk = 1'b1; di = 1'b1; end
      @(negedge clk);
      chk(do_oe == 0, "R8 cancel when ready", do_oe, 0);
      sk = 1'b0;
      di = 1'b0;
      // R9 deselect with nothing pending
      watch(1'b0, 1'b0, '0, '0, "R9 idle deselect");
      // R6 lock strobe during busy was ignored: writes still accepted
      pulse(0, 3'd2, 8'h22);
      watch(1'b1, 1'b0, 3'd2, 8'h22, "R6 lock still open");
    end

    // R3 lock closes again
    pulse(5, '0, '0);
    pulse(0, 3'd4, 8'h44);
    watch(1'b0, 1'b0, '0, '0, "R3 relocked");

    // R4 cycle length independent of sk toggling
    pulse(4, '0, '0);
    pulse(3, 3'd0, 8'hC3);
    fork
      watch(1'b1, 1'b1, 3'd0, 8'hC3, "R4 sk toggling");
      begin
        for (int i = 0; i < CYC + 3; i++) @(negedge clk) sk = ~sk;
      end
    join
    sk = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule